// File: doc/BRIEF.md
# Register-Register ALU Execute Stage

This block is the execute stage for the register-register operation class of a 16-bit control core. A 4-bit modifier selects one of sixteen operations. Each operation takes a destination register value, a source register value, an 8-bit input bus and a stored carry. The block returns the value to write back to the destination, an adjusted copy of the source pointer with its own write strobe, a write enable for the destination, and a flag that says when the bus priority scan found no zero bit. The register file, instruction fetch and memory traffic belong to other blocks. This stage only computes values.

Operations enter through a valid/ready handshake and leave through a single output register with its own valid/ready pair. `in_ready` is high when the output register is empty, or when its content is being taken in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds every field unchanged and accepts nothing new. The carry flag is a plain status output. It changes on the clock edge that loads the output register with an arithmetic result, so it always matches the result on display.

Top module: `regalu_exec`

## Requirements
- R1: After reset, `out_valid` is 0, `carry_flag` is 0 and `in_ready` is 1.
- R2: An operation is accepted on a rising edge where `in_valid` and `in_ready` are both 1. Results appear on the next cycle, in order, one per accepted operation. While `out_valid` is 1 and `out_ready` is 0, all outputs hold and `in_ready` is 0.
- R3: Modifiers 0, 1, 2, 3 and 4 give `out_ptr` = Ry−2, Ry−1, Ry+1, Ry+2 and Ry respectively, all modulo 2^16. `out_result` equals `out_ptr`. `out_ptr_we` is 1 for modifiers 0 to 3 and 0 for every other modifier.
- R4: Modifiers 5, 6 and 7 apply AND, OR and XOR to the low bytes of Rx and Ry. The high byte of the result is Rx's high byte.
- R5: Modifier 8 gives Rx + zero-extended Ry[7:0], and modifier 9 gives Rx − zero-extended Ry[7:0]. The carry flag takes the carry or borrow out of bit 15.
- R6: Modifier A gives Rx + Ry[7:0] + carry, and modifier B gives Rx − Ry[7:0] − carry. Both use the flag value from before the operation and update the flag as in R5.
- R7: Modifier C gives {Rx[15:8], Rx[15:8]}. Modifier D gives {Rx[7:0], Rx[7:0]}.
- R8: Modifier E gives {8'h00, bus}.
- R9: Modifier F scans the bus from bit 7 down to bit 0. If the first zero found is at bit 7−k, the result is Rx + 2k modulo 2^16, giving an addend in the range 0 to 0xE.
- R10: Modifier F with a bus of 8'hFF gives result = Rx, `out_nozero` = 1 and `out_wr_en` = 0. For every other operation, `out_nozero` is 0 and `out_wr_en` is 1.
- R11: Modifiers 0–7 and C–F leave the carry flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_op | input | 4 | Operation modifier |
| in_rx | input | 16 | Destination register value |
| in_ry | input | 16 | Source register / pointer value |
| in_bus | input | 8 | Input bus byte |
| out_valid | output | 1 | Result held in output register |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 16 | Value for the destination register |
| out_ptr | output | 16 | Adjusted source pointer |
| out_ptr_we | output | 1 | Source pointer write strobe |
| out_wr_en | output | 1 | Destination write strobe |
| out_nozero | output | 1 | Priority scan found no zero bit |
| carry_flag | output | 1 | Stored carry / borrow |

## Verification
The hardest case to reach is a chain of carry-dependent special adds running while the consumer stalls at irregular times. In that case the flag must advance once per accepted operation, never once per stalled cycle, and results sharing the edge with a pop must keep their order. The stimulus sets the carry from a wrapping add and then interleaves modifiers that must not touch it. It then runs a long mixed stream under pseudo-random `out_ready`, while a running carry model in the scoreboard predicts each item.

// File: rtl/regalu_pkg.sv
`timescale 1ns/1ps
package regalu_pkg;
  typedef enum logic [3:0] {
    OP_DEC2     = 4'h0,
    OP_DEC1     = 4'h1,
    OP_INC1     = 4'h2,
    OP_INC2     = 4'h3,
    OP_COPY     = 4'h4,
    OP_AND      = 4'h5,
    OP_OR       = 4'h6,
    OP_XOR      = 4'h7,
    OP_ADD      = 4'h8,
    OP_SUB      = 4'h9,
    OP_ADC      = 4'hA,
    OP_SBB      = 4'hB,
    OP_HI2LO    = 4'hC,
    OP_LO2HI    = 4'hD,
    OP_LDBUS    = 4'hE,
    OP_DISPATCH = 4'hF
  } alu_op_e;
endpackage

// File: rtl/regalu_ptr.sv
`timescale 1ns/1ps
module regalu_ptr #(
  parameter int W = 16
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] ry,
  output logic [W-1:0] ptr,
  output logic         ptr_we
);
  import regalu_pkg::*;

  always_comb begin
    ptr    = ry;
    ptr_we = 1'b1;
    case (alu_op_e'(op))
      OP_DEC2: ptr = ry - W'(2);
      OP_DEC1: ptr = ry - W'(1);
      OP_INC1: ptr = ry + W'(1);
      OP_INC2: ptr = ry + W'(2);
      default: ptr_we = 1'b0;
    endcase
  end
endmodule

// File: rtl/regalu_prio.sv
`timescale 1ns/1ps
module regalu_prio #(
  parameter int W     = 16,
  parameter int BUS_W = 8
) (
  input  logic [BUS_W-1:0] bus,
  output logic [W-1:0]     addend,
  output logic             none
);
  logic [BUS_W:0]   pass;
  logic [BUS_W-1:0] hit;

  assign pass[0] = 1'b1;
  for (genvar i = 0; i < BUS_W; i++) begin : g_scan
    assign hit[i]    = pass[i] & ~bus[BUS_W-1-i];
    assign pass[i+1] = pass[i] &  bus[BUS_W-1-i];
  end

  assign none = pass[BUS_W];

  always_comb begin
    addend = '0;
    for (int i = 0; i < BUS_W; i++) begin
      if (hit[i]) addend = W'(2 * i);
    end
  end
endmodule

// File: rtl/regalu_core.sv
`timescale 1ns/1ps
module regalu_core #(
  parameter int W     = 16,
  parameter int BUS_W = 8
) (
  input  logic [3:0]       op,
  input  logic [W-1:0]     rx,
  input  logic [W-1:0]     ry,
  input  logic [BUS_W-1:0] bus,
  input  logic             carry_in,
  output logic [W-1:0]     result,
  output logic [W-1:0]     ptr,
  output logic             ptr_we,
  output logic             wr_en,
  output logic             carry_out,
  output logic             carry_upd,
  output logic             nozero
);
  import regalu_pkg::*;

  localparam int B = W / 2;

  logic [W-1:0] addend;
  logic         none;
  logic [W:0]   ry_lo, ci, sum, diff, sumc, diffc;

  regalu_ptr #(.W(W)) ptr_i (
    .op(op), .ry(ry), .ptr(ptr), .ptr_we(ptr_we)
  );

  regalu_prio #(.W(W), .BUS_W(BUS_W)) prio_i (
    .bus(bus), .addend(addend), .none(none)
  );

  assign ry_lo = (W+1)'(ry[B-1:0]);
  assign ci    = (W+1)'(carry_in);
  assign sum   = {1'b0, rx} + ry_lo;
  assign diff  = {1'b0, rx} - ry_lo;
  assign sumc  = sum + ci;
  assign diffc = diff - ci;

  always_comb begin
    result    = rx;
    wr_en     = 1'b1;
    carry_out = carry_in;
    carry_upd = 1'b0;
    nozero    = 1'b0;
    case (alu_op_e'(op))
      OP_DEC2, OP_DEC1, OP_INC1, OP_INC2, OP_COPY: result = ptr;
      OP_AND: result = {rx[W-1:B], rx[B-1:0] & ry[B-1:0]};
      OP_OR:  result = {rx[W-1:B], rx[B-1:0] | ry[B-1:0]};
      OP_XOR: result = {rx[W-1:B], rx[B-1:0] ^ ry[B-1:0]};
      OP_ADD: begin {carry_out, result} = sum;   carry_upd = 1'b1; end
      OP_SUB: begin {carry_out, result} = diff;  carry_upd = 1'b1; end
      OP_ADC: begin {carry_out, result} = sumc;  carry_upd = 1'b1; end
      OP_SBB: begin {carry_out, result} = diffc; carry_upd = 1'b1; end
      OP_HI2LO: result = {rx[W-1:B], rx[W-1:B]};
      OP_LO2HI: result = {rx[B-1:0], rx[B-1:0]};
      OP_LDBUS: result = W'(bus);
      OP_DISPATCH: begin
        result = rx + addend;
        nozero = none;
        wr_en  = ~none;
      end
      default: result = rx;
    endcase
  end
endmodule

// File: rtl/regalu_exec.sv
`timescale 1ns/1ps
module regalu_exec #(
  parameter int W     = 16,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [3:0]       in_op,
  input  logic [W-1:0]     in_rx,
  input  logic [W-1:0]     in_ry,
  input  logic [BUS_W-1:0] in_bus,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_result,
  output logic [W-1:0]     out_ptr,
  output logic             out_ptr_we,
  output logic             out_wr_en,
  output logic             out_nozero,
  output logic             carry_flag
);
  logic [W-1:0] c_result, c_ptr;
  logic         c_ptr_we, c_wr_en, c_carry, c_carry_upd, c_nozero;
  logic         accept;

  regalu_core #(.W(W), .BUS_W(BUS_W)) core_i (
    .op(in_op), .rx(in_rx), .ry(in_ry), .bus(in_bus), .carry_in(carry_flag),
    .result(c_result), .ptr(c_ptr), .ptr_we(c_ptr_we), .wr_en(c_wr_en),
    .carry_out(c_carry), .carry_upd(c_carry_upd), .nozero(c_nozero)
  );

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_ptr    <= '0;
      out_ptr_we <= 1'b0;
      out_wr_en  <= 1'b0;
      out_nozero <= 1'b0;
      carry_flag <= 1'b0;
    end else begin
      if (accept) begin
        out_valid  <= 1'b1;
        out_result <= c_result;
        out_ptr    <= c_ptr;
        out_ptr_we <= c_ptr_we;
        out_wr_en  <= c_wr_en;
        out_nozero <= c_nozero;
        if (c_carry_upd) carry_flag <= c_carry;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/regalu_exec_chk.sv
`timescale 1ns/1ps
module regalu_exec_chk #(
  parameter int W     = 16,
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [3:0]       in_op,
  input logic [W-1:0]     in_rx,
  input logic [W-1:0]     in_ry,
  input logic [BUS_W-1:0] in_bus,
  input logic             out_valid,
  input logic             out_ready,
  input logic [W-1:0]     out_result,
  input logic [W-1:0]     out_ptr,
  input logic             out_ptr_we,
  input logic             out_wr_en,
  input logic             out_nozero,
  input logic             carry_flag
);
  localparam int B = W / 2;
  logic acc;
  assign acc = in_valid && in_ready;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_ptr) && $stable(out_ptr_we))); // R2

  AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R2

  AST_COPY_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == 4'h4) |=> (out_ptr == $past(in_ry) && !out_ptr_we)); // R3

  AST_LOGIC_HIGH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op >= 4'h5 && in_op <= 4'h7) |=> (out_result[W-1:B] == $past(in_rx[W-1:B]))); // R4

  AST_NOZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == 4'hF && (&in_bus)) |=> (out_nozero && !out_wr_en && out_result == $past(in_rx))); // R10

  AST_CARRY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_op < 4'h8 || in_op > 4'hB)) |=> (carry_flag == $past(carry_flag))); // R11
endmodule

bind regalu_exec regalu_exec_chk #(.W(W), .BUS_W(BUS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_rx(in_rx), .in_ry(in_ry), .in_bus(in_bus),
  .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
  .out_ptr(out_ptr), .out_ptr_we(out_ptr_we), .out_wr_en(out_wr_en),
  .out_nozero(out_nozero), .carry_flag(carry_flag)
);

// File: tb/regalu_exec_tb_top.sv
`timescale 1ns/1ps
module regalu_exec_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [15:0] in_rx = '0, in_ry = '0;
  logic [7:0]  in_bus = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_result, out_ptr;
  logic        out_ptr_we, out_wr_en, out_nozero, carry_flag;

  typedef struct {
    logic [15:0] res;
    logic [15:0] ptr;
    logic        pwe;
    logic        we;
    logic        nz;
    logic        cy;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_bad = 0;
  logic m_carry = 1'b0;
  logic stall_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  bit   done = 0;

  always #2.5 clk = ~clk;

  regalu_exec dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_rx(in_rx), .in_ry(in_ry), .in_bus(in_bus),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_ptr(out_ptr), .out_ptr_we(out_ptr_we), .out_wr_en(out_wr_en),
    .out_nozero(out_nozero), .carry_flag(carry_flag)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [3:0] op, input logic [15:0] rx,
                                 input logic [15:0] ry, input logic [7:0] bus,
                                 input logic cin);
    exp_t e;
    logic [16:0] w;
    int k;
    e.res = rx; e.ptr = ry; e.pwe = 0; e.we = 1; e.nz = 0; e.cy = cin; e.tag = "R4";
    case (op)
      4'h0, 4'h1, 4'h2, 4'h3, 4'h4: begin
        e.ptr = (op == 0) ? ry - 16'd2 : (op == 1) ? ry - 16'd1 :
                (op == 2) ? ry + 16'd1 : (op == 3) ? ry + 16'd2 : ry;
        e.pwe = (op != 4); e.res = e.ptr; e.tag = "R3";
      end
      4'h5: e.res = {rx[15:8], rx[7:0] & ry[7:0]};
      4'h6: e.res = {rx[15:8], rx[7:0] | ry[7:0]};
      4'h7: e.res = {rx[15:8], rx[7:0] ^ ry[7:0]};
      4'h8: begin w = {1'b0, rx} + {9'd0, ry[7:0]}; e.res = w[15:0]; e.cy = w[16]; e.tag = "R5"; end
      4'h9: begin w = {1'b0, rx} - {9'd0, ry[7:0]}; e.res = w[15:0]; e.cy = w[16]; e.tag = "R5"; end
      4'hA: begin w = {1'b0, rx} + {9'd0, ry[7:0]} + {16'd0, cin}; e.res = w[15:0]; e.cy = w[16]; e.tag = "R6"; end
      4'hB: begin w = {1'b0, rx} - {9'd0, ry[7:0]} - {16'd0, cin}; e.res = w[15:0]; e.cy = w[16]; e.tag = "R6"; end
      4'hC: begin e.res = {rx[15:8], rx[15:8]}; e.tag = "R7"; end
      4'hD: begin e.res = {rx[7:0], rx[7:0]}; e.tag = "R7"; end
      4'hE: begin e.res = {8'h00, bus}; e.tag = "R8"; end
      default: begin
        k = -1;
        for (int i = 7; i >= 0; i--) if (k < 0 && !bus[i]) k = 7 - i;
        if (k < 0) begin e.nz = 1; e.we = 0; e.res = rx; e.tag = "R10"; end
        else begin e.res = rx + 16'(2 * k); e.tag = "R9"; end
      end
    endcase
    return e;
  endfunction

  task automatic send(input logic [3:0] op, input logic [15:0] rx,
                      input logic [15:0] ry, input logic [7:0] bus);
    exp_t e;
    in_valid = 1; in_op = op; in_rx = rx; in_ry = ry; in_bus = bus;
    do @(negedge clk); while (!in_ready);
    e = model(op, rx, ry, bus, m_carry);
    m_carry = e.cy;
    exp_q.push_back(e);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  // out_ready driver and pattern source
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = stall_mode ? lfsr[0] : 1'b1;
  end

  // monitor / scoreboard
  logic        held = 0;
  logic [15:0] held_res;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held && out_valid)
        check(out_result == held_res, "R2", "stall hold", {16'd0, out_result}, {16'd0, held_res});
      held = out_valid && !out_ready;
      held_res = out_result;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R2", "unexpected result", {16'd0, out_result}, 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(out_result == e.res, e.tag, "result", {16'd0, out_result}, {16'd0, e.res});
          check(out_ptr_we == e.pwe, "R3", "ptr_we", {31'd0, out_ptr_we}, {31'd0, e.pwe});
          if (e.pwe) check(out_ptr == e.ptr, "R3", "ptr", {16'd0, out_ptr}, {16'd0, e.ptr});
          check(out_wr_en == e.we, "R10", "wr_en", {31'd0, out_wr_en}, {31'd0, e.we});
          check(out_nozero == e.nz, "R10", "nozero", {31'd0, out_nozero}, {31'd0, e.nz});
          check(carry_flag == e.cy, (e.tag == "R5" || e.tag == "R6") ? e.tag : "R11",
                "carry", {31'd0, carry_flag}, {31'd0, e.cy});
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "R2", "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [31:0] x;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(out_valid == 0, "R1", "out_valid", {31'd0, out_valid}, 32'd0);
    check(carry_flag == 0, "R1", "carry_flag", {31'd0, carry_flag}, 32'd0);
    check(in_ready == 1, "R1", "in_ready", {31'd0, in_ready}, 32'd1);
    @(posedge clk); #1;

    // R3 moves incl. wrap
    send(4'h0, 16'h1111, 16'h0000, 8'h00);
    send(4'h1, 16'h1111, 16'h0000, 8'h00);
    send(4'h2, 16'h1111, 16'hFFFF, 8'h00);
    send(4'h3, 16'h1111, 16'hFFFE, 8'h00);
    send(4'h4, 16'h1111, 16'h8001, 8'h00);
    // R4 logic
    send(4'h5, 16'hA5F0, 16'h12CC, 8'h00);
    send(4'h6, 16'hA5F0, 16'h120F, 8'h00);
    send(4'h7, 16'h5A3C, 16'hFFFF, 8'h00);
    // R5 add/sub with carry into high byte and out
    send(4'h8, 16'h00FF, 16'h0001, 8'h00);
    send(4'h8, 16'hFFFF, 16'h0001, 8'h00);   // carry set
    // R11 carry held across non-arith ops
    send(4'h5, 16'h0000, 16'h0000, 8'h00);
    send(4'hC, 16'hAB12, 16'h0000, 8'h00);
    send(4'hE, 16'h0000, 16'h0000, 8'h3C);
    send(4'hF, 16'h0100, 16'h0000, 8'hFF);
    // R6 carry in consumed
    send(4'hA, 16'h0000, 16'h0000, 8'h00);   // 0+0+1
    send(4'h9, 16'h0000, 16'h0001, 8'h00);   // borrow set
    send(4'hB, 16'h0010, 16'h0005, 8'h00);   // 0x10-5-1
    send(4'hB, 16'h0000, 16'h0000, 8'h00);   // 0-0-0
    // R7, R8
    send(4'hD, 16'hAB12, 16'h0000, 8'h00);
    send(4'hE, 16'hFFFF, 16'h0000, 8'h00);
    // R9, R10 priority patterns
    send(4'hF, 16'h1000, 16'h0000, 8'h7F);
    send(4'hF, 16'h1000, 16'h0000, 8'hBF);
    send(4'hF, 16'h1000, 16'h0000, 8'hFE);
    send(4'hF, 16'hFFFE, 16'h0000, 8'hF0);
    send(4'hF, 16'h1000, 16'h0000, 8'h00);
    send(4'hF, 16'h2222, 16'h0000, 8'hFF);

    // mixed stream under back-pressure (R2, R6, R11)
    stall_mode = 1;
    x = 32'h1234_5678;
    for (int n = 0; n < 300; n++) begin
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      send(x[3:0], x[19:4], x[31:16], (x[4]) ? 8'hFF : x[27:20]);
    end
    stall_mode = 0;
    for (int t = 0; t < 200 && exp_q.size() != 0; t++) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R2", "results outstanding", exp_q.size(), 32'd0);
    finish_run();
  end
endmodule